// File: doc/BRIEF.md
# Increment/Decrement Pulse Trimmer

This block is the controlled oscillator of an all-digital first-order phase-locked loop. It is clocked by the increment/decrement reference clock. On `pulse_o` it gives one output pulse for every two reference cycles. Each pulse is a single reference cycle wide, and the stage downstream ANDs it with the reference clock or uses it as a clock enable. The nominal output rate is therefore half the reference frequency. An external divide-by-N stage then sets the loop centre frequency at the reference frequency divided by 2N.

The loop counter runs on a separate clock. It sends two kinds of single-cycle strobe. A carry strobe inserts exactly one extra pulse: a slot that would have been low is driven high. A borrow strobe removes exactly one pulse: a slot that would have been high is driven low. Each strobe crosses into the reference domain as a toggle through a synchronizer chain. It is then held as a pending request until the next slot whose polarity it can change. A carry and a borrow that are outstanding together cancel each other, and neither is applied.

Top module: `idclk_pulse_trim`

## Requirements
- R1: While `rst_n` is low, `pulse_o` is low and no request is pending. After release, the first sampled reference cycle is low and the output then runs 0,1,0,1.
- R2: With no request outstanding, `pulse_o` changes value on every reference clock rising edge, so it is high on exactly one cycle in two.
- R3: One carry strobe adds exactly one high cycle to the output, in a slot that would otherwise have been low. The count over any window that contains it rises by one.
- R4: One borrow strobe removes exactly one high cycle from the output, by forcing a slot that would otherwise have been high to low. The count over any window that contains it falls by one.
- R5: A carry and a borrow strobe in the same counter clock cycle cancel. So do a carry and a borrow that are both outstanding in the same reference cycle. The output keeps its nominal pattern.
- R6: A request is applied at the first slot of the matching polarity. It is never pending for more than one reference cycle, and its effect shows on `pulse_o` within SYNC_STAGES+6 reference cycles of the strobe.
- R7: Strobes spaced at least SYNC_STAGES+3 reference cycles apart each take effect. The change in pulse count over a window equals the number of carries minus the number of borrows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| idclk_i | input | 1 | Increment/decrement reference clock; `pulse_o` changes only on its rising edge |
| kclk_i | input | 1 | Loop counter clock on which the strobes are sampled |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| carry_i | input | 1 | One counter-clock-cycle strobe: add one output pulse |
| borrow_i | input | 1 | One counter-clock-cycle strobe: remove one output pulse |
| pulse_o | output | 1 | One-reference-cycle-wide output pulses, nominally every second cycle |

## Verification
A table drives windows of 128 reference cycles with no strobes, with single and repeated carries, and with single and repeated borrows. It also drives mixed carries and borrows, and carry/borrow pairs issued in the same counter cycle. Each window's pulse count is compared with 64 plus carries minus borrows. A quiet window separates a correct half-rate output from a stuck or doubled one. Single and repeated windows show whether every strobe counts once. Mixed and simultaneous windows show whether the two directions net off correctly, or whether a cancelled pair leaks a pulse. Directed tests check the waveform shape: a double high after a carry and a double low after a borrow, both within a bounded delay. They also check the exact 0,1,0,1 start after power-up reset and after a reset applied in mid-run.

// File: rtl/idpa_pkg.sv
package idpa_pkg;

  // Default depth of the strobe synchronizer chain
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // What a reference-clock slot does with the outstanding requests
  typedef enum logic [1:0] {
    SLOT_KEEP   = 2'd0,
    SLOT_ADD    = 2'd1,
    SLOT_DEL    = 2'd2,
    SLOT_CANCEL = 2'd3
  } slot_act_e;

  // A request can only change a slot whose nominal level it inverts:
  // adds take low slots (phase 0), deletes take high slots (phase 1).
  function automatic slot_act_e pick_action(input logic add_req,
                                            input logic del_req,
                                            input logic phase);
    if (add_req && del_req) return SLOT_CANCEL;
    if (add_req && !phase)  return SLOT_ADD;
    if (del_req && phase)   return SLOT_DEL;
    return SLOT_KEEP;
  endfunction

  // Output level for a slot: nominal level is the phase bit itself
  function automatic logic slot_value(input slot_act_e act, input logic phase);
    case (act)
      SLOT_ADD: return 1'b1;
      SLOT_DEL: return 1'b0;
      default:  return phase;
    endcase
  endfunction

endpackage

// File: rtl/idpa_strobe_xfer.sv
module idpa_strobe_xfer #(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic event_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic             src_tgl;
  logic [LAST:0]    sync_q;
  logic             seen_q;

  // Source domain: every strobe flips a level
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)        src_tgl <= 1'b0;
    else if (strobe_i) src_tgl <= ~src_tgl;
  end

  // Destination domain: synchronizer chain
  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= src_tgl;
      end
    end else begin : g_next
      always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= sync_q[LAST];
  end

  // One destination cycle per level change
  assign event_o = sync_q[LAST] ^ seen_q;

endmodule

// File: rtl/idpa_slot_engine.sv
module idpa_slot_engine
  import idpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic add_ev,
  input  logic del_ev,
  output logic pulse_o,
  output logic phase_o,
  output logic pend_add_o,
  output logic pend_del_o,
  output logic add_fire_o,
  output logic del_fire_o
);

  logic      phase_q;
  logic      pulse_q;
  logic      pend_add_q;
  logic      pend_del_q;
  logic      add_req;
  logic      del_req;
  slot_act_e act;

  always_comb begin
    add_req = pend_add_q | add_ev;
    del_req = pend_del_q | del_ev;
    act     = pick_action(add_req, del_req, phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= 1'b0;
      pulse_q    <= 1'b0;
      pend_add_q <= 1'b0;
      pend_del_q <= 1'b0;
    end else begin
      phase_q    <= ~phase_q;
      pulse_q    <= slot_value(act, phase_q);
      pend_add_q <= add_req && (act == SLOT_KEEP);
      pend_del_q <= del_req && (act == SLOT_KEEP);
    end
  end

  assign pulse_o    = pulse_q;
  assign phase_o    = phase_q;
  assign pend_add_o = pend_add_q;
  assign pend_del_o = pend_del_q;
  assign add_fire_o = (act == SLOT_ADD);
  assign del_fire_o = (act == SLOT_DEL);

endmodule

// File: rtl/idclk_pulse_trim.sv
module idclk_pulse_trim
  import idpa_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic idclk_i,
  input  logic kclk_i,
  input  logic rst_n,
  input  logic carry_i,
  input  logic borrow_i,
  output logic pulse_o
);

  logic add_ev;
  logic del_ev;
  logic phase;
  logic pend_add;
  logic pend_del;
  logic add_fire;
  logic del_fire;

  idpa_strobe_xfer #(.STAGES(SYNC_STAGES)) carry_xfer_i (
    .src_clk (kclk_i),
    .dst_clk (idclk_i),
    .rst_n   (rst_n),
    .strobe_i(carry_i),
    .event_o (add_ev)
  );

  idpa_strobe_xfer #(.STAGES(SYNC_STAGES)) borrow_xfer_i (
    .src_clk (kclk_i),
    .dst_clk (idclk_i),
    .rst_n   (rst_n),
    .strobe_i(borrow_i),
    .event_o (del_ev)
  );

  idpa_slot_engine engine_i (
    .clk       (idclk_i),
    .rst_n     (rst_n),
    .add_ev    (add_ev),
    .del_ev    (del_ev),
    .pulse_o   (pulse_o),
    .phase_o   (phase),
    .pend_add_o(pend_add),
    .pend_del_o(pend_del),
    .add_fire_o(add_fire),
    .del_fire_o(del_fire)
  );

endmodule

module idclk_pulse_trim_chk (
  input logic idclk_i,
  input logic rst_n,
  input logic add_ev,
  input logic del_ev,
  input logic pend_add,
  input logic pend_del,
  input logic add_fire,
  input logic del_fire,
  input logic pulse_o
);

  logic [1:0] age;
  logic       idle;

  always_ff @(posedge idclk_i or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assign idle = !add_ev && !del_ev && !pend_add && !pend_del;

  // R2
  quiet_alternates_chk: assert property (@(posedge idclk_i) disable iff (!rst_n)
    (age == 2'd2 && idle && $past(idle)) |=> (pulse_o != $past(pulse_o)));

  // R5
  pair_cancels_chk: assert property (@(posedge idclk_i) disable iff (!rst_n)
    (add_ev && del_ev) |=> (!pend_add && !pend_del));

  // R6
  add_wait_short_chk: assert property (@(posedge idclk_i) disable iff (!rst_n)
    pend_add |=> !pend_add);

  // R6
  del_wait_short_chk: assert property (@(posedge idclk_i) disable iff (!rst_n)
    pend_del |=> !pend_del);

  // R3
  add_gives_high_chk: assert property (@(posedge idclk_i) disable iff (!rst_n)
    add_fire |=> pulse_o);

  // R4
  del_gives_low_chk: assert property (@(posedge idclk_i) disable iff (!rst_n)
    del_fire |=> !pulse_o);

endmodule

bind idclk_pulse_trim idclk_pulse_trim_chk chk_i (
  .idclk_i (idclk_i),
  .rst_n   (rst_n),
  .add_ev  (add_ev),
  .del_ev  (del_ev),
  .pend_add(pend_add),
  .pend_del(pend_del),
  .add_fire(add_fire),
  .del_fire(del_fire),
  .pulse_o (pulse_o)
);

// File: tb/idclk_pulse_trim_tb_top.sv
`timescale 1ns/1ps
module idclk_pulse_trim_tb_top;

  localparam int SYNC = 2;
  localparam int WIN  = 128;
  localparam int GAP  = 12;
  localparam int NV   = 9;
  // carries, borrows, simultaneous pairs, expected count change
  localparam int VC[NV] = '{0, 1, 0, 3, 0, 2, 0, 1, 1};
  localparam int VB[NV] = '{0, 0, 1, 0, 3, 1, 0, 1, 2};
  localparam int VP[NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 1};
  localparam int VE[NV] = '{0, 1, -1, 3, -3, 1, 0, 0, -1};

  logic idclk = 1'b0;
  logic kclk  = 1'b0;
  logic rst_n = 1'b0;
  logic carry_i = 1'b0;
  logic borrow_i = 1'b0;
  logic pulse_o;

  int total = 0;
  int fails = 0;

  always #2.5 idclk = ~idclk;
  always #3.5 kclk  = ~kclk;

  idclk_pulse_trim #(.SYNC_STAGES(SYNC)) dut_i (
    .idclk_i (idclk),
    .kclk_i  (kclk),
    .rst_n   (rst_n),
    .carry_i (carry_i),
    .borrow_i(borrow_i),
    .pulse_o (pulse_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic kstrobe(input logic c, input logic b);
    @(negedge kclk);
    carry_i  = c;
    borrow_i = b;
    @(negedge kclk);
    carry_i  = 1'b0;
    borrow_i = 1'b0;
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge idclk);
      cnt += int'(pulse_o);
    end
  endtask

  task automatic fire_mix(input int nc, input int nb, input int np);
    repeat (4) @(negedge idclk);
    for (int i = 0; i < nc; i++) begin kstrobe(1'b1, 1'b0); repeat (GAP) @(negedge kclk); end
    for (int i = 0; i < nb; i++) begin kstrobe(1'b0, 1'b1); repeat (GAP) @(negedge kclk); end
    for (int i = 0; i < np; i++) begin kstrobe(1'b1, 1'b1); repeat (GAP) @(negedge kclk); end
  endtask

  // Looks for two equal consecutive samples of the given level
  task automatic find_double(input logic lvl, input int limit, output int at);
    logic prev;
    at = -1;
    prev = ~lvl;
    for (int i = 0; i < limit; i++) begin
      @(negedge idclk);
      if (pulse_o == lvl && prev == lvl && at < 0) at = i;
      prev = pulse_o;
    end
  endtask

  task automatic check_start(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge idclk);
      check(pulse_o == logic'(i % 2), tag, int'(pulse_o), i % 2);
    end
  endtask

  initial begin
    #(200000 * 5);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int cnt;
    int at;
    int diffs;
    logic prev;

    // R1: reset state and first pattern
    repeat (5) @(negedge idclk);
    check(pulse_o == 1'b0, "R1 reset level", int'(pulse_o), 0);
    rst_n = 1'b1;
    check_start("R1 start pattern");

    // R2: quiet alternation
    diffs = 0;
    @(negedge idclk);
    prev = pulse_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge idclk);
      if (pulse_o != prev) diffs++;
      prev = pulse_o;
    end
    check(diffs == 20, "R2 quiet alternation", diffs, 20);

    // R3/R4/R5/R7 vector table
    for (int v = 0; v < NV; v++) begin
      automatic int c2;
      fork
        count_pulses(WIN, c2);
        fire_mix(VC[v], VB[v], VP[v]);
      join
      check(c2 == WIN / 2 + VE[v], $sformatf("R3/R4/R5/R7 vector %0d", v), c2, WIN / 2 + VE[v]);
      repeat (4) @(negedge idclk);
    end

    // R3, R6: carry shows as a double high within the latency bound
    repeat (6) @(negedge idclk);
    fork
      kstrobe(1'b1, 1'b0);
      find_double(1'b1, SYNC + 10, at);
    join
    check(at >= 0 && at <= SYNC + 8, "R3/R6 carry double high", at, SYNC + 8);

    // R4, R6: borrow shows as a double low within the latency bound
    repeat (6) @(negedge idclk);
    fork
      kstrobe(1'b0, 1'b1);
      find_double(1'b0, SYNC + 10, at);
    join
    check(at >= 0 && at <= SYNC + 8, "R4/R6 borrow double low", at, SYNC + 8);

    // R1: reset in mid-run with a carry on its way
    repeat (6) @(negedge idclk);
    kstrobe(1'b1, 1'b0);
    @(negedge idclk);
    rst_n = 1'b0;
    #1;
    check(pulse_o == 1'b0, "R1 mid-run reset level", int'(pulse_o), 0);
    repeat (4) @(negedge idclk);
    rst_n = 1'b1;
    check_start("R1 restart pattern");
    count_pulses(WIN, cnt);
    check(cnt == WIN / 2, "R1 no leftover request", cnt, WIN / 2);

    summary();
  end

endmodule